// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous static RAM. The host presents one word access at a time: a read or a write, with address and write data held on a level request until a one-cycle acknowledge comes back. The controller turns each request into a strobe sequence for the RAM. It holds the address steady, drives active-low chip, output and write enables, and controls a split data bus made of an outgoing word, an incoming word and a drive enable. Every strobe and the drive enable come straight from flip-flops.

Each RAM timing limit is a nanosecond parameter. It becomes a whole number of clock cycles through a ceiling division by the clock-period parameter, and any non-zero limit takes at least one cycle. After reset the controller waits out a long supply settling time before it serves the first request. Writes are controlled by write enable, and output enable stays low during them. The controller therefore first waits for the RAM to let go of the bus and only then drives data. It ends the write by raising write enable while chip enable is still low, and it drops its own drive on that same edge. Every access ends with a turnaround gap in which chip and output enable are both high.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset is released, chip enable stays high and no acknowledge is given for at least ceil(T_POWERUP_NS/CLK_NS) cycles. A request already pending in that time is served once the time has passed.
- R2: During reset all three enables are high (inactive), the drive enable is low and the acknowledge is low.
- R3: A read holds chip and output enable low and write enable high, with the address stable. It captures the incoming word after at least ceil(T_AA_NS/CLK_NS) cycles of strobe. The acknowledge goes high on the (RD+2)-th falling clock edge counted from the first falling edge at which chip enable is seen low, where RD = max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)-1). While it is high, the returned data equals the RAM word at that address.
- R4: Write enable is low only while chip enable is low, and the address does not change while chip enable stays low.
- R5: During a write, the drive enable stays low for the first ceil(T_HZWE_NS/CLK_NS) cycles of write enable low.
- R6: During a write, write data is driven for at least ceil(T_SD_NS/CLK_NS) cycles before write enable rises, and write enable stays low for at least ceil(T_PWE_NS/CLK_NS) cycles. The word driven before the rise is the word later read back from that address.
- R7: The drive enable is high only while write enable and chip enable are both low. It is low again no later than the edge on which write enable rises.
- R8: Between two accesses, chip enable stays high for at least ceil(T_HZOE_NS/CLK_NS) cycles.
- R9: Only one request is served at a time. The acknowledge is a single-cycle pulse. Changes to write flag, address or data after a request has been accepted have no effect on that access, and a request held for one cycle after its acknowledge is not served twice.
- R10: A write is acknowledged on the (HZ+DATA+1)-th falling edge counted from the first falling edge at which chip enable is seen low. Here HZ = ceil(T_HZWE_NS/CLK_NS), and DATA is the largest of ceil(T_SD_NS/CLK_NS), ceil(T_PWE_NS/CLK_NS)-HZ, ceil(T_SCE_NS/CLK_NS)-HZ, ceil(T_AW_NS/CLK_NS)-HZ, ceil(T_WC_NS/CLK_NS)-HZ and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request, held until acknowledged |
| hostWrite | input | 1 | 1 selects write, 0 selects read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | DATA_W | Word to write |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | DATA_W | Captured read word, valid with the acknowledge of a read |
| sramAddr | output | ADDR_W | RAM address bus |
| sramDataOut | output | DATA_W | Word the controller puts on the RAM bus |
| sramDataIn | input | DATA_W | Word the RAM puts on the bus |
| sramDataOe | output | 1 | Controller drives the bus when high |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |

## Verification
The bench counts falling clock edges from the first edge at which chip enable is seen low. A read must acknowledge exactly RD+2 edges later and a write exactly HZ+DATA+1 edges later, and the bench compares against those indices. The first access after reset must wait at least the power-up cycle count. A bench RAM model returns wrong data until the read strobe has been active for the access time, so early sampling shows up as bad read data. A monitor at each falling edge measures write-enable pulse width, the drive window before the write-enable rise, the drive delay after write enable falls and the chip-enable gap. It checks each one at the event that closes it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RD_STROBE,
    ST_RD_SAMPLE,
    ST_WR_RELEASE,
    ST_WR_DATA,
    ST_WR_END,
    ST_RECOVER
  } ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic captureRd;
  } dp_strobe_t;

  function automatic int unsigned nsToCycles(int unsigned ns, int unsigned clkNs);
    if (ns == 0) return 0;
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int unsigned atLeastOne(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned floorSub(int unsigned a, int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/sram_delay_timer.sv
module sram_delay_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(RESET_VAL);
    end else if (load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned PWR_CYC  = 4,
  parameter int unsigned RD_CYC   = 1,
  parameter int unsigned HZWE_CYC = 1,
  parameter int unsigned DATA_CYC = 1,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned CNT_W    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWrite,
  output logic       hostAck,
  output logic       sramCeN,
  output logic       sramOeN,
  output logic       sramWeN,
  output logic       sramDataOe,
  output dp_strobe_t strb
);

  localparam logic [CNT_W-1:0] LOAD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_HZWE = CNT_W'(HZWE_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_DATA = CNT_W'(DATA_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_TURN = CNT_W'(TURN_CYC - 1);

  ctrl_state_t      state, nextState;
  logic             timerLoad, timerZero;
  logic [CNT_W-1:0] timerVal;
  logic             ackNext;

  sram_delay_timer #(
    .CNT_W    (CNT_W),
    .RESET_VAL(PWR_CYC - 1)
  ) uTimer (
    .clk    (clk),
    .rstN   (rstN),
    .load   (timerLoad),
    .loadVal(timerVal),
    .zero   (timerZero)
  );

  always_comb begin
    nextState = state;
    timerLoad = 1'b0;
    timerVal  = '0;
    strb      = '0;
    ackNext   = 1'b0;
    case (state)
      ST_PWRUP: begin
        if (timerZero) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (hostReq) begin
          strb.loadReq = 1'b1;
          timerLoad    = 1'b1;
          if (hostWrite) begin
            nextState = ST_WR_RELEASE;
            timerVal  = LOAD_HZWE;
          end else begin
            nextState = ST_RD_STROBE;
            timerVal  = LOAD_RD;
          end
        end
      end
      ST_RD_STROBE: begin
        if (timerZero) nextState = ST_RD_SAMPLE;
      end
      ST_RD_SAMPLE: begin
        strb.captureRd = 1'b1;
        ackNext        = 1'b1;
        nextState      = ST_RECOVER;
        timerLoad      = 1'b1;
        timerVal       = LOAD_TURN;
      end
      ST_WR_RELEASE: begin
        if (timerZero) begin
          nextState = ST_WR_DATA;
          timerLoad = 1'b1;
          timerVal  = LOAD_DATA;
        end
      end
      ST_WR_DATA: begin
        if (timerZero) begin
          nextState = ST_WR_END;
          ackNext   = 1'b1;
        end
      end
      ST_WR_END: begin
        nextState = ST_RECOVER;
        timerLoad = 1'b1;
        timerVal  = LOAD_TURN;
      end
      ST_RECOVER: begin
        if (timerZero) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // pin levels decoded from the next state and registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_PWRUP;
      sramCeN    <= 1'b1;
      sramOeN    <= 1'b1;
      sramWeN    <= 1'b1;
      sramDataOe <= 1'b0;
      hostAck    <= 1'b0;
    end else begin
      state      <= nextState;
      sramCeN    <= !(nextState inside {ST_RD_STROBE, ST_RD_SAMPLE,
                                        ST_WR_RELEASE, ST_WR_DATA, ST_WR_END});
      sramOeN    <= !(nextState inside {ST_RD_STROBE, ST_RD_SAMPLE,
                                        ST_WR_RELEASE, ST_WR_DATA, ST_WR_END});
      sramWeN    <= !(nextState inside {ST_WR_RELEASE, ST_WR_DATA});
      sramDataOe <= (nextState == ST_WR_DATA);
      hostAck    <= ackNext;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] sramDataIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDataOut,
  output logic [DATA_W-1:0] hostRdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr    <= '0;
      sramDataOut <= '0;
    end else if (strb.loadReq) begin
      sramAddr    <= hostAddr;
      sramDataOut <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (strb.captureRd) begin
      hostRdata <= sramDataIn;
    end
  end

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_NS       = 4,
  parameter int unsigned T_POWERUP_NS = 100000,
  parameter int unsigned T_RC_NS      = 10,
  parameter int unsigned T_AA_NS      = 10,
  parameter int unsigned T_HZOE_NS    = 5,
  parameter int unsigned T_WC_NS      = 10,
  parameter int unsigned T_SCE_NS     = 8,
  parameter int unsigned T_AW_NS      = 8,
  parameter int unsigned T_PWE_NS     = 7,
  parameter int unsigned T_SD_NS      = 5,
  parameter int unsigned T_HZWE_NS    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDataOut,
  input  logic [DATA_W-1:0] sramDataIn,
  output logic              sramDataOe,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN
);

  localparam int unsigned PWR_CYC  = atLeastOne(nsToCycles(T_POWERUP_NS, CLK_NS));
  localparam int unsigned RD_CYC   = atLeastOne(maxOf(nsToCycles(T_AA_NS, CLK_NS),
                                       floorSub(nsToCycles(T_RC_NS, CLK_NS), 1)));
  localparam int unsigned HZWE_CYC = atLeastOne(nsToCycles(T_HZWE_NS, CLK_NS));
  localparam int unsigned DATA_CYC = atLeastOne(maxOf(
      maxOf(nsToCycles(T_SD_NS, CLK_NS),
            floorSub(nsToCycles(T_PWE_NS, CLK_NS), HZWE_CYC)),
      maxOf(maxOf(floorSub(nsToCycles(T_SCE_NS, CLK_NS), HZWE_CYC),
                  floorSub(nsToCycles(T_AW_NS, CLK_NS), HZWE_CYC)),
            floorSub(nsToCycles(T_WC_NS, CLK_NS), HZWE_CYC))));
  localparam int unsigned TURN_CYC = atLeastOne(nsToCycles(T_HZOE_NS, CLK_NS));
  localparam int unsigned MAX_CYC  = maxOf(maxOf(PWR_CYC, RD_CYC),
                                       maxOf(maxOf(HZWE_CYC, DATA_CYC), TURN_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  dp_strobe_t strb;

  sram_ctrl_fsm #(
    .PWR_CYC (PWR_CYC),
    .RD_CYC  (RD_CYC),
    .HZWE_CYC(HZWE_CYC),
    .DATA_CYC(DATA_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .hostAck   (hostAck),
    .sramCeN   (sramCeN),
    .sramOeN   (sramOeN),
    .sramWeN   (sramWeN),
    .sramDataOe(sramDataOe),
    .strb      (strb)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .sramDataIn (sramDataIn),
    .sramAddr   (sramAddr),
    .sramDataOut(sramDataOut),
    .hostRdata  (hostRdata)
  );

endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned PWR_CYC  = 4,
  parameter int unsigned HZWE_CYC = 1,
  parameter int unsigned TURN_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic              sramDataOe,
  input logic [ADDR_W-1:0] sramAddr
);

  logic [31:0] pwrCnt, weLowCnt, ceHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt    <= '0;
      weLowCnt  <= '0;
      ceHighCnt <= 32'(TURN_CYC);
    end else begin
      if (pwrCnt < 32'(PWR_CYC)) pwrCnt <= pwrCnt + 1;
      weLowCnt  <= sramWeN ? '0 : weLowCnt + 1;
      ceHighCnt <= !sramCeN ? '0 :
                   (ceHighCnt < 32'(TURN_CYC) ? ceHighCnt + 1 : ceHighCnt);
    end
  end

  AST_QUIET_POWERUP: assert property (@(posedge clk) disable iff (!rstN)
    (pwrCnt < 32'(PWR_CYC)) |-> (sramCeN && !hostAck)); // R1
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && sramWeN) |-> !sramOeN); // R3
  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr)); // R4
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDataOe) |-> (weLowCnt >= 32'(HZWE_CYC))); // R5
  AST_DRIVE_IN_WE: assert property (@(posedge clk) disable iff (!rstN)
    sramDataOe |-> (!sramWeN && !sramCeN)); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramCeN) |-> (ceHighCnt >= 32'(TURN_CYC))); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck); // R9

endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .PWR_CYC (PWR_CYC),
  .HZWE_CYC(HZWE_CYC),
  .TURN_CYC(TURN_CYC)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .hostAck   (hostAck),
  .sramCeN   (sramCeN),
  .sramOeN   (sramOeN),
  .sramWeN   (sramWeN),
  .sramDataOe(sramDataOe),
  .sramAddr  (sramAddr)
);

// File: tb/tb_sram_access_ctrl.sv
module tb_sram_access_ctrl;

  localparam int CLK_PERIOD = 4;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic int cyc(int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_PWR  = cyc(100000);
  localparam int B_AA   = cyc(10);
  localparam int B_RD   = imax(cyc(10), cyc(10) - 1);
  localparam int B_HZ   = cyc(5);
  localparam int B_SD   = cyc(5);
  localparam int B_PWE  = cyc(7);
  localparam int B_TURN = cyc(5);
  localparam int B_DATA = imax(imax(imax(B_SD, cyc(7) - B_HZ), imax(cyc(8) - B_HZ, cyc(10) - B_HZ)), 1);
  localparam int RD_ACK = B_RD + 2;
  localparam int WR_ACK = B_HZ + B_DATA + 1;

  logic clk = 1'b0;
  logic rstN;
  logic hostReq, hostWrite, hostAck;
  logic [ADDR_W-1:0] hostAddr, sramAddr;
  logic [DATA_W-1:0] hostWdata, hostRdata, sramDataOut, sramDataIn;
  logic sramDataOe, sramCeN, sramOeN, sramWeN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit monOn = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_PERIOD)) dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostAck(hostAck),
    .hostRdata(hostRdata), .sramAddr(sramAddr), .sramDataOut(sramDataOut),
    .sramDataIn(sramDataIn), .sramDataOe(sramDataOe), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // RAM model: bad data until the read strobe has lasted the access time
  logic [DATA_W-1:0] mem    [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];
  int rdCnt = 0;
  logic [DATA_W-1:0] wrLatch;
  bit wrLatched = 0;
  logic mPrevWeN = 1'b1;
  logic [ADDR_W-1:0] mPrevAddr = '0;

  assign sramDataIn = (rdCnt >= B_AA) ? mem[sramAddr] : ~mem[sramAddr];

  always @(negedge clk) begin
    if (!sramCeN && !sramOeN && sramWeN) rdCnt = rdCnt + 1;
    else rdCnt = 0;
    if (!sramCeN && !sramWeN && sramDataOe) begin
      wrLatch = sramDataOut;
      wrLatched = 1;
    end
    if (sramWeN && !mPrevWeN) begin
      if (wrLatched) mem[mPrevAddr] = wrLatch;
      wrLatched = 0;
    end
    mPrevWeN  = sramWeN;
    mPrevAddr = sramAddr;
  end

  // pin protocol monitor
  int weLow = 0, driveRun = 0, ceHigh = 0;
  bit firstAccess = 1;
  bit addrMoved = 0;
  logic pCeN = 1'b1, pWeN = 1'b1, pOe = 1'b0, pAck = 1'b0;
  logic [ADDR_W-1:0] pAddr = '0;

  always @(negedge clk) begin
    if (monOn) begin
      if (!sramWeN) weLow++;
      if (sramDataOe) driveRun++;
      if (sramDataOe && !pOe)
        chk(weLow >= B_HZ + 1, "R5 drive after WE low", weLow, B_HZ + 1);
      if (sramDataOe && (sramWeN || sramCeN))
        chk(0, "R7 drive outside WE/CE overlap", 1, 0);
      if (!sramWeN && sramCeN)
        chk(0, "R4 WE low with CE high", 1, 0);
      if (sramWeN && !pWeN) begin
        chk(!sramDataOe, "R7 drive released at WE rise", sramDataOe, 0);
        chk(weLow >= B_PWE, "R6 WE pulse width", weLow, B_PWE);
        chk(driveRun >= B_SD, "R6 data setup", driveRun, B_SD);
        weLow = 0;
        driveRun = 0;
      end
      if (!sramCeN && !pCeN && sramAddr != pAddr) addrMoved = 1;
      if (sramCeN && !pCeN) begin
        chk(!addrMoved, "R4 address held", addrMoved, 0);
        addrMoved = 0;
      end
      if (sramCeN) ceHigh++;
      if (!sramCeN && pCeN) begin
        if (!firstAccess) chk(ceHigh >= B_TURN, "R8 turnaround gap", ceHigh, B_TURN);
        firstAccess = 0;
        ceHigh = 0;
      end
      if (hostAck && pAck) chk(0, "R9 ack wider than one cycle", 2, 1);
    end
    pCeN = sramCeN; pWeN = sramWeN; pOe = sramDataOe; pAck = hostAck; pAddr = sramAddr;
  end

  // one access; mode 1 disturbs inputs mid-access, mode 2 holds req after ack
  task automatic doOp(bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                      int mode, int limit, output int waited);
    int n = 0;
    int guard = 0;
    bit started = 0;
    bit sawWe = 0;
    bit gotAck = 0;
    waited = 0;
    hostReq = 1; hostWrite = wr; hostAddr = a; hostWdata = d;
    while (guard < limit) begin
      @(negedge clk);
      guard++;
      if (!started && hostAck) chk(0, "R1 ack before access", 1, 0);
      if (!started && !sramCeN) begin
        started = 1;
        waited = guard;
      end
      if (started) n++;
      if (!sramWeN) sawWe = 1;
      if (mode == 1 && n == 1) begin
        hostWrite = ~wr; hostAddr = ~a; hostWdata = ~d;
      end
      if (hostAck) begin
        gotAck = 1;
        break;
      end
    end
    if (!gotAck) chk(0, "R9 access never acknowledged", guard, limit);
    else if (wr) begin
      chk(n == WR_ACK, "R10 write ack index", n, WR_ACK);
      shadow[a] = d;
    end else begin
      chk(n == RD_ACK, "R3 read ack index", n, RD_ACK);
      chk(hostRdata == shadow[a], "R3 read data", hostRdata, shadow[a]);
      if (mode == 1) chk(!sawWe, "R9 write flag ignored while busy", sawWe, 0);
    end
    if (mode == 2) @(negedge clk);
    hostReq = 0;
    if (mode == 2) begin
      bit again = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!sramCeN) again = 1;
      end
      chk(!again, "R9 held request served once", again, 0);
    end
  endtask

  initial begin
    int w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'($urandom);
      shadow[i] = mem[i];
    end
    rstN = 0; hostReq = 0; hostWrite = 0; hostAddr = '0; hostWdata = '0;
    repeat (5) @(negedge clk);
    chk(sramCeN && sramOeN && sramWeN && !sramDataOe && !hostAck, "R2 reset state",
        {sramCeN, sramOeN, sramWeN, sramDataOe, hostAck}, 5'b11100);
    rstN = 1;
    monOn = 1;
    // R1: request pending through power-up
    doOp(0, 10'd5, '0, 0, B_PWR + 100, w);
    chk(w >= B_PWR, "R1 power-up wait", w, B_PWR);
    chk(w <= B_PWR + 2, "R1 pending request served", w, B_PWR + 2);
    // directed corners
    doOp(1, '1, 8'hFF, 0, 100, w);
    doOp(0, '1, '0, 0, 100, w);
    doOp(1, '0, 8'h00, 0, 100, w);
    doOp(1, '0, 8'h5A, 0, 100, w);
    doOp(0, '0, '0, 0, 100, w);
    doOp(0, '0, '0, 1, 100, w);       // R9 inputs change mid-read
    doOp(1, 10'd77, 8'hC3, 1, 100, w); // R9 inputs change mid-write
    doOp(0, 10'd77, '0, 2, 100, w);   // R9 request held past ack
    doOp(0, ~10'd77, '0, 0, 100, w);  // disturbed write did not reach this address
    // random mix (R6 data checked by later reads)
    for (int k = 0; k < 300; k++) begin
      logic [ADDR_W-1:0] ra = ADDR_W'($urandom_range(0, 15));
      doOp(1'($urandom_range(0, 1)), ra, DATA_W'($urandom), 0, 100, w);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    for (int k = 0; k < 16; k++) doOp(0, ADDR_W'(k), '0, 0, 100, w);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected<%0d", 200000, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule